// File: doc/BRIEF.md
# Word-Oriented Shift Register with Extension-Field Feedback

This block holds sixteen 32-bit words in a shift chain. On every advance each word moves one place toward stage 0. The top stage receives a feedback word built from three stages. That word does not come from single-bit taps. The lowest stage is shifted up by one byte and mixed with a byte-indexed multiply-by-alpha word. The stage at index 2 is XORed in whole. The stage at index 11 is shifted down by one byte and mixed with a byte-indexed divide-by-alpha word. Both alpha words are concatenations of repeated doublings in GF(2^8), each doubling reduced with the constant 0xA9.

The block is meant to sit under a nonlinear combiner. That combiner reads the exported stages 0, 2, 5, 11 and 15. During warm-up it feeds a 32-bit word back through `ext_word` with `init_mode` high. During output generation `init_mode` is low and the external word plays no part. A parallel load writes all sixteen words at once. The two alpha mappings are fixed 256-entry tables, each computed at elaboration from the doubling rule.

The internal operation is one of three named states, decoded each cycle. LOAD is entered whenever `load_en` is high. SHIFT is entered when `shift_en` is high and `load_en` is low. HOLD is entered when both are low. The feedback has two named modes. INIT is selected by `init_mode` = 1. KEYSTREAM is selected by `init_mode` = 0.

Top module: `wlfsr_core`

## Requirements
- R1: While `rst_n` is low, all sixteen stages are cleared to zero, and every exported tap reads 0.
- R2: With `load_en` high at a clock edge, stage i takes `load_data[32*i+31 : 32*i]` for every i from 0 to 15, all in that single edge.
- R3: When `load_en` and `shift_en` are both high, the load is performed and no shift takes place.
- R4: With `shift_en` high and `load_en` low, each stage i below 15 takes the old value of stage i+1.
- R5: On a shift in KEYSTREAM mode, stage 15 takes v = (s0 << 8) ^ MA(s0[31:24]) ^ s2 ^ (s11 >> 8) ^ DA(s11[7:0]). Both byte shifts are logical and fill with zeros.
- R6: On a shift in INIT mode (`init_mode` = 1), stage 15 takes v ^ `ext_word`.
- R7: In KEYSTREAM mode (`init_mode` = 0), `ext_word` has no effect on any stage.
- R8: With `load_en` and `shift_en` both low, every stage keeps its value, whatever `init_mode` and `ext_word` are.
- R9: MA(c) is a 32-bit word. From the most to the least significant byte, its bytes are c doubled 23, 245, 48 and 239 times. One doubling shifts the byte left by one and XORs 0xA9 when the old bit 7 was set.
- R10: DA(c) is a 32-bit word built with the same doubling and the same byte order, from c doubled 16, 39, 6 and 64 times.
- R11: `tap_s0`, `tap_s2`, `tap_s5`, `tap_s11` and `tap_s15` show the current contents of stages 0, 2, 5, 11 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Parallel load of all stages; takes priority over shift |
| load_data | input | 512 | Load words; stage i sits in bits 32*i+31 to 32*i |
| shift_en | input | 1 | Advance the chain by one word |
| init_mode | input | 1 | 1 selects INIT feedback (ext_word mixed in); 0 selects KEYSTREAM |
| ext_word | input | 32 | External word XORed into the feedback in INIT mode |
| tap_s0 | output | 32 | Stage 0 contents |
| tap_s2 | output | 32 | Stage 2 contents |
| tap_s5 | output | 32 | Stage 5 contents |
| tap_s11 | output | 32 | Stage 11 contents |
| tap_s15 | output | 32 | Stage 15 contents |

## Verification
The bench builds the block with its default parameters: sixteen stages, taps at 2, 5 and 11, and reduction constant 0xA9. This puts the real 256-entry alpha tables within reach. Single-byte loads are placed in stage 0 or stage 11 with every other stage zero, so one shift shows MA or DA alone on `tap_s15`, including the bytes 0x80 and 0xFF whose doublings reduce on the first step. Long random runs in both feedback modes, and cycles where load and shift are both high, are compared on every clock against a queue-based model. That model recomputes each doubling chain at run time.

// File: rtl/wlfsr_pkg.sv
package wlfsr_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int TBL_N    = 256;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    typedef enum logic {
        FB_KSTREAM = 1'b0,
        FB_INIT    = 1'b1
    } fbmode_e;

    typedef enum logic {
        MAP_MUL = 1'b0,
        MAP_DIV = 1'b1
    } map_kind_e;

    // one doubling in GF(2^8) with the given reduction constant
    function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] poly);
        logic [BYTE_W-1:0] sh;
        sh = {v[BYTE_W-2:0], 1'b0};
        return v[BYTE_W-1] ? (sh ^ poly) : sh;
    endfunction

    // n doublings in a row, evaluated at elaboration only
    function automatic logic [BYTE_W-1:0] gf_dbl_n(input logic [BYTE_W-1:0] v,
                                                   input int n,
                                                   input logic [BYTE_W-1:0] poly);
        logic [BYTE_W-1:0] acc;
        acc = v;
        for (int k = 0; k < n; k++) acc = gf_dbl(acc, poly);
        return acc;
    endfunction

    // word of four doubling chains, most significant byte first
    function automatic logic [WORD_W-1:0] gf_word(input logic [BYTE_W-1:0] c,
                                                  input int e3, input int e2,
                                                  input int e1, input int e0,
                                                  input logic [BYTE_W-1:0] poly);
        return {gf_dbl_n(c, e3, poly), gf_dbl_n(c, e2, poly),
                gf_dbl_n(c, e1, poly), gf_dbl_n(c, e0, poly)};
    endfunction

endpackage

// File: rtl/wlfsr_alpha_map.sv
module wlfsr_alpha_map
    import wlfsr_pkg::*;
#(
    parameter map_kind_e        KIND = MAP_MUL,
    parameter logic [BYTE_W-1:0] POLY = 8'hA9
) (
    input  logic [BYTE_W-1:0] idx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] tbl [TBL_N];

    // the parameter picks the exponent set for the table
    if (KIND == MAP_MUL) begin : g_mul
        for (genvar gi = 0; gi < TBL_N; gi++) begin : g_ent
            localparam logic [WORD_W-1:0] ENT = gf_word(BYTE_W'(gi), 23, 245, 48, 239, POLY);
            assign tbl[gi] = ENT;
        end
    end else begin : g_div
        for (genvar gi = 0; gi < TBL_N; gi++) begin : g_ent
            localparam logic [WORD_W-1:0] ENT = gf_word(BYTE_W'(gi), 16, 39, 6, 64, POLY);
            assign tbl[gi] = ENT;
        end
    end

    assign word = tbl[idx];

endmodule

// File: rtl/wlfsr_feedback.sv
module wlfsr_feedback
    import wlfsr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'hA9
) (
    input  logic [WORD_W-1:0] s_lo,
    input  logic [WORD_W-1:0] s_mid,
    input  logic [WORD_W-1:0] s_hi,
    input  logic [WORD_W-1:0] ext_word,
    input  fbmode_e           mode,
    output logic [WORD_W-1:0] fb_base,
    output logic [WORD_W-1:0] fb_word
);

    logic [WORD_W-1:0] mul_w;
    logic [WORD_W-1:0] div_w;

    wlfsr_alpha_map #(.KIND(MAP_MUL), .POLY(POLY)) u_mul (
        .idx  (s_lo[WORD_W-1 -: BYTE_W]),
        .word (mul_w)
    );

    wlfsr_alpha_map #(.KIND(MAP_DIV), .POLY(POLY)) u_div (
        .idx  (s_hi[BYTE_W-1:0]),
        .word (div_w)
    );

    assign fb_base = {s_lo[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ mul_w ^ s_mid
                   ^ {{BYTE_W{1'b0}}, s_hi[WORD_W-1:BYTE_W]} ^ div_w;

    always_comb begin
        unique case (mode)
            FB_INIT:    fb_word = fb_base ^ ext_word;
            FB_KSTREAM: fb_word = fb_base;
            default:    fb_word = fb_base;
        endcase
    end

endmodule

// File: rtl/wlfsr_stages.sv
module wlfsr_stages
    import wlfsr_pkg::*;
#(
    parameter int NSTAGE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  op_e                      op,
    input  logic [NSTAGE*WORD_W-1:0] load_data,
    input  logic [WORD_W-1:0]        fb_word,
    output logic [NSTAGE*WORD_W-1:0] stages_flat
);

    logic [WORD_W-1:0] stg_q [NSTAGE];
    logic [WORD_W-1:0] stg_d [NSTAGE];

    for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stg
        logic [WORD_W-1:0] shift_src;

        if (gi == NSTAGE - 1) begin : g_top
            assign shift_src = fb_word;
        end else begin : g_mid
            assign shift_src = stg_q[gi+1];
        end

        always_comb begin
            unique case (op)
                OP_LOAD:  stg_d[gi] = load_data[gi*WORD_W +: WORD_W];
                OP_SHIFT: stg_d[gi] = shift_src;
                OP_HOLD:  stg_d[gi] = stg_q[gi];
                default:  stg_d[gi] = stg_q[gi];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[gi] <= '0;
            else        stg_q[gi] <= stg_d[gi];
        end

        assign stages_flat[gi*WORD_W +: WORD_W] = stg_q[gi];
    end

endmodule

// File: rtl/wlfsr_core.sv
module wlfsr_core
    import wlfsr_pkg::*;
#(
    parameter int               NSTAGE  = 16,
    parameter int               TAP_MID = 2,
    parameter int               TAP_NL  = 5,
    parameter int               TAP_DIV = 11,
    parameter logic [7:0]       POLY    = 8'hA9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en,
    input  logic [NSTAGE*32-1:0]      load_data,
    input  logic                      shift_en,
    input  logic                      init_mode,
    input  logic [31:0]               ext_word,
    output logic [31:0]               tap_s0,
    output logic [31:0]               tap_s2,
    output logic [31:0]               tap_s5,
    output logic [31:0]               tap_s11,
    output logic [31:0]               tap_s15
);

    localparam int TOP = NSTAGE - 1;

    op_e                      op;
    fbmode_e                  fb_mode;
    logic [WORD_W-1:0]        fb_base;
    logic [WORD_W-1:0]        fb_word;
    logic [NSTAGE*WORD_W-1:0] stages_flat;

    // operation decode: load wins over shift
    always_comb begin
        if (load_en)       op = OP_LOAD;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_HOLD;
    end

    assign fb_mode = init_mode ? FB_INIT : FB_KSTREAM;

    wlfsr_feedback #(.POLY(POLY)) u_fb (
        .s_lo     (stages_flat[0 +: WORD_W]),
        .s_mid    (stages_flat[TAP_MID*WORD_W +: WORD_W]),
        .s_hi     (stages_flat[TAP_DIV*WORD_W +: WORD_W]),
        .ext_word (ext_word),
        .mode     (fb_mode),
        .fb_base  (fb_base),
        .fb_word  (fb_word)
    );

    wlfsr_stages #(.NSTAGE(NSTAGE)) u_stg (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .load_data   (load_data),
        .fb_word     (fb_word),
        .stages_flat (stages_flat)
    );

    assign tap_s0  = stages_flat[0 +: WORD_W];
    assign tap_s2  = stages_flat[TAP_MID*WORD_W +: WORD_W];
    assign tap_s5  = stages_flat[TAP_NL*WORD_W +: WORD_W];
    assign tap_s11 = stages_flat[TAP_DIV*WORD_W +: WORD_W];
    assign tap_s15 = stages_flat[TOP*WORD_W +: WORD_W];

endmodule

// File: rtl/wlfsr_chk.sv
module wlfsr_chk #(
    parameter int NSTAGE = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_en,
    input logic                 shift_en,
    input logic                 init_mode,
    input logic [31:0]          ext_word,
    input logic [NSTAGE*32-1:0] load_data,
    input logic [NSTAGE*32-1:0] stages_flat,
    input logic [31:0]          fb_base,
    input logic [31:0]          tap_s15
);

    p_load_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> stages_flat == $past(load_data));

    p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && shift_en) |=> tap_s15 == $past(load_data[NSTAGE*32-1 -: 32]));

    p_shift_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en) |=>
            stages_flat[(NSTAGE-1)*32-1:0] == $past(stages_flat[NSTAGE*32-1:32]));

    p_init_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && init_mode) |=> tap_s15 == $past(fb_base ^ ext_word));

    p_ext_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && !init_mode) |=> tap_s15 == $past(fb_base));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(stages_flat));

endmodule

bind wlfsr_core wlfsr_chk #(.NSTAGE(NSTAGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .shift_en    (shift_en),
    .init_mode   (init_mode),
    .ext_word    (ext_word),
    .load_data   (load_data),
    .stages_flat (stages_flat),
    .fb_base     (fb_base),
    .tap_s15     (tap_s15)
);

// File: tb/sim_wlfsr_core.sv
module sim_wlfsr_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [511:0] load_data = '0;
    logic         shift_en = 1'b0;
    logic         init_mode = 1'b0;
    logic [31:0]  ext_word = '0;
    logic [31:0]  tap_s0, tap_s2, tap_s5, tap_s11, tap_s15;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] mq[$];

    always #5 clk = ~clk;

    wlfsr_core u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .shift_en(shift_en), .init_mode(init_mode), .ext_word(ext_word),
        .tap_s0(tap_s0), .tap_s2(tap_s2), .tap_s5(tap_s5),
        .tap_s11(tap_s11), .tap_s15(tap_s15)
    );

    // reference arithmetic, evaluated at run time
    function automatic logic [7:0] twice(input logic [7:0] x);
        logic [7:0] y;
        y = x << 1;
        if (x[7]) y = y ^ 8'hA9;
        return y;
    endfunction

    function automatic logic [7:0] power(input logic [7:0] x, input int n);
        logic [7:0] y;
        y = x;
        repeat (n) y = twice(y);
        return y;
    endfunction

    function automatic logic [31:0] ref_ma(input logic [7:0] c);
        return {power(c, 23), power(c, 245), power(c, 48), power(c, 239)};
    endfunction

    function automatic logic [31:0] ref_da(input logic [7:0] c);
        return {power(c, 16), power(c, 39), power(c, 6), power(c, 64)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "s0",  tap_s0,  mq[0]);
        chk(req, "s2",  tap_s2,  mq[2]);
        chk(req, "s5",  tap_s5,  mq[5]);
        chk(req, "s11", tap_s11, mq[11]);
        chk(req, "s15", tap_s15, mq[15]);
    endtask

    // drive one cycle (called just after a falling edge), update model, compare
    task automatic step(input bit ld, input bit sh, input bit im,
                        input logic [31:0] ew, input logic [511:0] ldd,
                        input string req);
        logic [31:0] v;
        load_en = ld; shift_en = sh; init_mode = im; ext_word = ew; load_data = ldd;
        if (ld) begin
            mq.delete();
            for (int i = 0; i < 16; i++) mq.push_back(ldd[i*32 +: 32]);
        end else if (sh) begin
            v = (mq[0] << 8) ^ ref_ma(mq[0][31:24]) ^ mq[2]
              ^ (mq[11] >> 8) ^ ref_da(mq[11][7:0]);
            if (im) v = v ^ ew;
            void'(mq.pop_front());
            mq.push_back(v);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    function automatic logic [511:0] rand_load();
        logic [511:0] d;
        for (int i = 0; i < 16; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    function automatic logic [511:0] one_word(input int idx, input logic [31:0] w);
        logic [511:0] d;
        d = '0;
        d[idx*32 +: 32] = w;
        return d;
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] seqd;
        logic [7:0]   bytes [6];
        bytes = '{8'h01, 8'h80, 8'hFF, 8'h5A, 8'h00, 8'h3C};
        for (int i = 0; i < 16; i++) mq.push_back(32'h0);

        // R1: reset state
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2 / R11: distinct word per stage shows which stage each tap reads
        for (int i = 0; i < 16; i++) seqd[i*32 +: 32] = 32'hA5000000 | (i << 8) | i;
        step(1, 0, 0, 32'h0, seqd, "R2");
        chk("R11", "tap_s5 index",  tap_s5,  32'hA5000505);
        chk("R11", "tap_s11 index", tap_s11, 32'hA5000B0B);

        // R4: plain shifts with ext ignored
        for (int k = 0; k < 6; k++) step(0, 1, 0, $urandom, '0, "R4");

        // R9: stage 0 holds one byte on top, all else zero
        foreach (bytes[b]) begin
            step(1, 0, 0, 32'h0, one_word(0, {bytes[b], 24'h0}), "R9");
            step(0, 1, 0, 32'h0, '0, "R9");
            chk("R9", "MA alone on s15", tap_s15, ref_ma(bytes[b]));
        end

        // R10: stage 11 holds one low byte, all else zero
        foreach (bytes[b]) begin
            step(1, 0, 0, 32'h0, one_word(11, {24'h0, bytes[b]}), "R10");
            step(0, 1, 0, 32'h0, '0, "R10");
            chk("R10", "DA plus shift on s15", tap_s15, ref_da(bytes[b]));
        end

        // R5: long keystream runs from random loads
        for (int r = 0; r < 4; r++) begin
            step(1, 0, 0, 32'h0, rand_load(), "R5");
            for (int k = 0; k < 40; k++) step(0, 1, 0, 32'h0, '0, "R5");
        end

        // R6: initialization-mode shifts with external words
        step(1, 0, 1, 32'h0, rand_load(), "R6");
        for (int k = 0; k < 40; k++) step(0, 1, 1, $urandom, '0, "R6");

        // R7: keystream shifts with busy ext_word
        step(1, 0, 0, 32'h0, rand_load(), "R7");
        for (int k = 0; k < 40; k++) step(0, 1, 0, $urandom | 32'h1, '0, "R7");

        // R3: load and shift in the same cycle
        for (int k = 0; k < 4; k++) begin
            step(1, 1, k[0], $urandom, rand_load(), "R3");
            step(0, 1, 1, $urandom, '0, "R3");
        end

        // R8: hold with moving mode and ext inputs
        for (int k = 0; k < 10; k++) step(0, 0, k[0], $urandom, rand_load(), "R8");

        // mixed traffic
        for (int k = 0; k < 200; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      step(1, $urandom_range(0, 1) == 1, 0, $urandom, rand_load(), "R2");
            else if (sel == 1) step(0, 0, 1, $urandom, '0, "R8");
            else               step(0, 1, $urandom_range(0, 1) == 1, $urandom, '0, "R5");
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule